// File: doc/BRIEF.md
# Register-ALU Datapath with Opcode Decoder

This block runs one 16-bit instruction per clock through a small single-cycle datapath. An opcode decoder turns the top four bits of the instruction into an ALU function code, an operand-source select and a write enable. The two source-register fields address a sixteen-entry register file that has two combinational read ports. The low four bits serve either as the second register address or as a signed immediate. A sign extender widens that immediate to the data width. A 2:1 multiplexer passes either the second register value or the extended immediate to the ALU. The ALU result is written back to the destination register on the rising clock edge.

The instruction layout is opcode in [15:12], destination register in [11:8], first source register in [7:4], and second source register or immediate in [3:0]. The opcodes are ADD 0000, SUB 0001, AND 0010, OR 0011, ADDI 0100 and SUBI 0101. Codes 0110 through 1111 write nothing. A synchronous clear zeroes the whole register file. The result of each accepted instruction is also captured in an output register, so a testbench can observe the datapath.

Top module: `rdp_core`

## Requirements
- R1: The decoder maps opcodes to ALU function codes as follows: 00 add for ADD and ADDI, 01 subtract for SUB and SUBI, 10 bitwise AND, 11 bitwise OR. The source select is 1 only for ADDI (0100) and SUBI (0101).
- R2: ADD (0000) writes reg[rs1] + reg[rs2] modulo 2^16 into reg[rd].
- R3: SUB (0001) writes reg[rs1] - reg[rs2] modulo 2^16 into reg[rd]. There are no flags.
- R4: AND (0010) and OR (0011) write the bitwise AND or OR of reg[rs1] and reg[rs2] into reg[rd].
- R5: ADDI (0100) writes reg[rs1] + sext(imm). Here imm is instr[3:0], and sext copies imm bit 3 into bits 15:4. This gives an immediate range of -8 to +7.
- R6: SUBI (0101) writes reg[rs1] - sext(imm) modulo 2^16.
- R7: While clr is high at a rising edge, every register becomes zero and alu_res becomes zero on that edge. The instruction present on that edge is ignored.
- R8: Opcodes 0110 to 1111 change no register, and alu_res keeps its previous value.
- R9: A source register that is also the destination supplies its value from before the edge. The new value is visible to the instruction in the next cycle.
- R10: alu_res shows the result of a valid instruction after the rising edge at which that instruction was presented. It holds that value until the next valid instruction or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr | input | 1 | Synchronous active-high clear of register file and result |
| instr | input | 16 | Instruction word: opcode, rd, rs1, rs2/immediate |
| alu_res | output | 16 | Registered ALU result of the last accepted instruction |

## Verification
Each instruction or clear presented before a rising edge has exactly one due point: alu_res after that same edge. A register write made at that edge is first seen by the instruction in the following cycle. The driver changes the instruction at the falling edge. It computes the expected result from a bench-side register model and queues it. The monitor takes one queued item 1 ns after each rising edge, so every comparison lands just after the edge that registers the result. Invalid opcodes queue the previous result, and later reads of the untouched registers expose any stray write.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  localparam logic [3:0] OPC_ADD  = 4'b0000;
  localparam logic [3:0] OPC_SUB  = 4'b0001;
  localparam logic [3:0] OPC_AND  = 4'b0010;
  localparam logic [3:0] OPC_OR   = 4'b0011;
  localparam logic [3:0] OPC_ADDI = 4'b0100;
  localparam logic [3:0] OPC_SUBI = 4'b0101;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    wr_en;
    logic    use_imm;
    alu_op_e op;
  } ctrl_t;

endpackage

// File: rtl/rdp_decoder.sv
module rdp_decoder
  import rdp_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl.wr_en   = 1'b1;
    ctrl.use_imm = 1'b0;
    ctrl.op      = ALU_ADD;
    case (opc)
      OPC_ADD:  ctrl.op = ALU_ADD;
      OPC_SUB:  ctrl.op = ALU_SUB;
      OPC_AND:  ctrl.op = ALU_AND;
      OPC_OR:   ctrl.op = ALU_OR;
      OPC_ADDI: begin
        ctrl.op      = ALU_ADD;
        ctrl.use_imm = 1'b1;
      end
      OPC_SUBI: begin
        ctrl.op      = ALU_SUB;
        ctrl.use_imm = 1'b1;
      end
      default:  ctrl.wr_en = 1'b0;
    endcase
  end

  // Immediate source only ever accompanies a valid write
  always_comb begin
    if (!$isunknown(opc)) begin
      AST_IMM_NEEDS_WRITE: assert (!ctrl.use_imm || ctrl.wr_en) // R1
        else $error("immediate select without write enable");
    end
  end

endmodule

// File: rtl/rdp_sext.sv
module rdp_sext #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  d,
  output logic [OUT_W-1:0] q
);

  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign q = {{PAD_W{d[IN_W-1]}}, d};
    end else begin : g_pass
      assign q = d[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/rdp_mux2.sv
module rdp_mux2 #(
  parameter int W = 16
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] y
);

  assign y = sel ? in1 : in0;

endmodule

// File: rtl/rdp_regfile.sv
module rdp_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [DATA_W-1:0]        wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  input  logic [$clog2(DEPTH)-1:0] rb,
  output logic [DATA_W-1:0]        qa,
  output logic [DATA_W-1:0]        qb
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              armed;

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign qa = mem[ra];
  assign qb = mem[rb];

  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (qa == '0 && qb == '0)) // R7
    else $error("register file not zero after clear");

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed || clr)
    (we && ra == wa) |=> (qa == $past(wd) || $past(wa) != ra || $past(clr))) // R9
    else $error("write data not visible next cycle");

endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
  import rdp_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, a, b}) && op == ALU_SUB) begin
      AST_SUB_WRAPS: assert (W'(y + b) == a) // R3
        else $error("subtraction does not wrap");
    end
  end

endmodule

// File: rtl/rdp_core.sv
module rdp_core
  import rdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int OPC_W  = 4
) (
  input  logic                              clk,
  input  logic                              clr,
  input  logic [OPC_W+3*$clog2(NREG)-1:0]   instr,
  output logic [DATA_W-1:0]                 alu_res
);

  localparam int AW      = $clog2(NREG);
  localparam int IMM_W   = AW;
  localparam int INSTR_W = OPC_W + 3 * AW;
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RD_LSB  = 2 * AW;
  localparam int RS1_LSB = AW;

  logic [OPC_W-1:0]  f_opc;
  logic [AW-1:0]     f_rd;
  logic [AW-1:0]     f_rs1;
  logic [AW-1:0]     f_rs2;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] res_q;
  logic              armed;

  assign f_opc = instr[INSTR_W-1:OPC_LSB];
  assign f_rd  = instr[RD_LSB +: AW];
  assign f_rs1 = instr[RS1_LSB +: AW];
  assign f_rs2 = instr[AW-1:0];

  rdp_decoder #(.OPC_W(OPC_W)) u_dec (
    .opc  (f_opc),
    .ctrl (ctrl)
  );

  rdp_regfile #(.DATA_W(DATA_W), .DEPTH(NREG)) u_rf (
    .clk (clk),
    .clr (clr),
    .we  (ctrl.wr_en),
    .wa  (f_rd),
    .wd  (alu_y),
    .ra  (f_rs1),
    .rb  (f_rs2),
    .qa  (rd_a),
    .qb  (rd_b)
  );

  rdp_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_sext (
    .d (f_rs2),
    .q (imm_ext)
  );

  rdp_mux2 #(.W(DATA_W)) u_bsel (
    .sel (ctrl.use_imm),
    .in0 (rd_b),
    .in1 (imm_ext),
    .y   (opnd_b)
  );

  rdp_alu #(.W(DATA_W)) u_alu (
    .op (ctrl.op),
    .a  (rd_a),
    .b  (opnd_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      res_q <= '0;
    end else if (ctrl.wr_en) begin
      res_q <= alu_y;
    end
  end

  assign alu_res = res_q;

  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  AST_CLEAR_OUTPUT: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (alu_res == '0)) // R7
    else $error("output not zero after clear");

  AST_HOLD_ON_INVALID: assert property (@(posedge clk) disable iff (!armed || clr)
    !ctrl.wr_en |=> $stable(alu_res)) // R8
    else $error("output moved on invalid opcode");

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!armed || clr)
    ctrl.wr_en |=> (alu_res == $past(alu_y))) // R10
    else $error("result not registered one edge later");

  AST_IMM_OPERAND: assert property (@(posedge clk) disable iff (!armed)
    ctrl.use_imm |-> (opnd_b == {{(DATA_W-IMM_W){f_rs2[IMM_W-1]}}, f_rs2})) // R5
    else $error("immediate operand not sign extended");

endmodule

// File: tb/rdp_core_tb.sv
module rdp_core_tb;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [15:0] instr = '0;
  logic [15:0] alu_res;

  always #2 clk = ~clk;

  rdp_core u_dut (
    .clk     (clk),
    .clr     (clr),
    .instr   (instr),
    .alu_res (alu_res)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [15:0] model [16];
  logic [15:0] last_res = '0;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done = 1'b0;

  function automatic logic [15:0] sext4(input logic [3:0] f);
    return {{12{f[3]}}, f};
  endfunction

  task automatic issue(input logic c, input logic [3:0] opc, input logic [3:0] rd,
                       input logic [3:0] rs1, input logic [3:0] f, input string tag);
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    bit          ok;
    item_t       it;
    @(negedge clk);
    clr   = c;
    instr = {opc, rd, rs1, f};
    a  = model[rs1];
    b  = (opc == 4'd4 || opc == 4'd5) ? sext4(f) : model[f];
    ok = 1'b1;
    r  = '0;
    case (opc)
      4'd0, 4'd4: r = a + b;
      4'd1, 4'd5: r = a - b;
      4'd2:       r = a & b;
      4'd3:       r = a | b;
      default:    ok = 1'b0;
    endcase
    if (c) begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      last_res = '0;
    end else if (ok) begin
      model[rd] = r;
      last_res  = r;
    end
    it.exp = last_res;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        n_checks++;
        if (alu_res !== it.exp) begin
          n_fails++;
          $display("FAIL %s: alu_res=%h expected %h", it.tag, alu_res, it.exp);
        end
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 16; i++) model[i] = '0;
    // reset state
    issue(1'b1, 4'd0, 4'd0, 4'd0, 4'd0, "R7 reset");
    issue(1'b1, 4'd0, 4'd0, 4'd0, 4'd0, "R7 reset");
    // immediates, including both range ends
    issue(1'b0, 4'd4, 4'd1, 4'd0, 4'd5,  "R5 R1 addi +5");
    issue(1'b0, 4'd4, 4'd2, 4'd0, 4'hD,  "R5 addi -3");
    issue(1'b0, 4'd4, 4'd10, 4'd0, 4'h7, "R5 addi max");
    issue(1'b0, 4'd4, 4'd11, 4'd0, 4'h8, "R5 addi min");
    // register forms
    issue(1'b0, 4'd0, 4'd3, 4'd1, 4'd2, "R2 R1 add");
    issue(1'b0, 4'd1, 4'd4, 4'd0, 4'd1, "R3 R1 sub wrap");
    issue(1'b0, 4'd2, 4'd5, 4'd2, 4'd1, "R4 R1 and");
    issue(1'b0, 4'd3, 4'd6, 4'd1, 4'd2, "R4 R1 or");
    issue(1'b0, 4'd2, 4'd12, 4'd2, 4'd11, "R4 and neg");
    // subtract immediate, positive and negative immediate
    issue(1'b0, 4'd5, 4'd7, 4'd1, 4'h7, "R6 R1 subi +7");
    issue(1'b0, 4'd5, 4'd7, 4'd7, 4'h8, "R6 subi -8");
    // same register as source and destination, then reuse
    issue(1'b0, 4'd0, 4'd1, 4'd1, 4'd1, "R9 self add");
    issue(1'b0, 4'd0, 4'd13, 4'd1, 4'd0, "R9 new value read");
    // invalid opcodes target r1: output holds, r1 untouched
    for (int k = 6; k < 16; k++)
      issue(1'b0, 4'(k), 4'd1, 4'd2, 4'd2, "R8 invalid hold");
    issue(1'b0, 4'd0, 4'd8, 4'd1, 4'd0, "R8 r1 untouched");
    issue(1'b0, 4'd4, 4'd9, 4'd9, 4'd1, "R10 result per edge");
    issue(1'b0, 4'd4, 4'd9, 4'd9, 4'd1, "R10 result per edge");
    // clear with a valid instruction present
    issue(1'b1, 4'd4, 4'd1, 4'd1, 4'd7, "R7 clear ignores instr");
    issue(1'b0, 4'd3, 4'd14, 4'd1, 4'd6, "R7 regs zero after clear");
    issue(1'b0, 4'd0, 4'd15, 4'd8, 4'd10, "R7 regs zero after clear");
    // pseudo-random mix, invalid codes and rare clears included
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      for (int s = 0; s < 16; s++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = lfsr;
      issue((w[15:9] == 7'h5A), {1'b0, w[14:12]} | (w[11] & w[10] ? 4'b1000 : 4'b0000),
            w[3:0], w[7:4], w[11:8], "R2 R3 R4 R5 R6 R8 R9 mix");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule